// File: doc/BRIEF.md
# Multi-Band Squared-Distance Engine

This block measures how far one multi-band image pixel lies from every stored training vector of every class. A host loads training vectors into a small local weight store. An upstream pixel controller then hands over one pixel at a time. For each training vector, the engine takes the band samples in turn. It subtracts the stored sample from the pixel sample as a signed quantity, squares the difference and sums the squares over all bands. It then emits the sum together with the index of the class that the vector belongs to.

The engine visits the classes in ascending order. Within each class it visits the vectors in ascending order, and within each vector it visits the bands in ascending order, one band per clock. The number of vectors used per class is taken from a configuration input when the pixel is accepted. When the last vector of the last class has produced its distance, the engine pulses a completion strobe and asks the controller for the next pixel.

After reset the engine first offers a link-ready handshake to the controller. It accepts no pixel until that handshake has been acknowledged.

The controller in `sqd_ctrl` has five named states:
- `ST_LINK` drives link-ready and waits for `link_ack` (LINK→IDLE).
- `ST_IDLE` drives the pixel request and waits for `pix_valid` (IDLE→RUN on accept).
- `ST_RUN` issues one band read per cycle and leaves after the final band of the final vector of the last class (RUN→DRAIN).
- `ST_DRAIN` lets the read and accumulate stages empty (DRAIN→FIN).
- `ST_FIN` asserts completion for one cycle (FIN→IDLE).

Top module: `sqd_accum`

## Requirements
- R1: After reset `link_rdy` is 1 while `pix_req`, `dist_valid` and `done` are 0. This holds until `link_ack` is sampled high, and `pix_valid` has no effect in that time.
- R2: One cycle after `link_ack` is taken, `pix_req` is 1. A pixel and `wpc_cfg` are captured at the clock edge where `pix_req` and `pix_valid` are both high, and `pix_req` is 0 in the following cycle.
- R3: Each band contributes (pixel − weight)², with both 10-bit samples treated as unsigned and the difference as 11-bit signed. The 20-bit squares are summed over the 4 bands into the 22-bit `dist_value`. For example, 4 × 1023² = 4186116 whichever sign the differences have.
- R4: Band b of the pixel sits at `pix_data[10b+9:10b]`. Weight (class c, vector w, band b) is stored at address (c·8 + w)·4 + b. Distances come out for c = 0..4 in ascending order, and within each class for w = 0..n−1; `dist_class` carries c.
- R5: `dist_valid` is high for exactly one cycle per vector, so there are 5·n strobes per pixel. Successive strobes are exactly 4 cycles apart.
- R6: The running sum restarts at the first band of every vector, so no vector's distance includes any part of a previous vector or a previous pixel.
- R7: The per-class vector count n equals `wpc_cfg`, except that 0 is treated as 1 and values above 8 are treated as 8.
- R8: `done` is high for exactly one cycle per pixel, in the same cycle as the final `dist_valid`. `pix_req` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_rdy | output | 1 | Engine is ready after reset and waits for acknowledgement |
| link_ack | input | 1 | Controller acknowledges link-ready |
| wpc_cfg | input | 4 | Vectors per class, captured with the pixel |
| pix_req | output | 1 | Engine requests the next pixel |
| pix_valid | input | 1 | Controller presents a pixel |
| pix_data | input | 40 | Four 10-bit band samples, band 0 in the low bits |
| wmem_we | input | 1 | Weight store write enable |
| wmem_addr | input | 8 | Weight store write address |
| wmem_wdata | input | 10 | Weight sample to write |
| dist_valid | output | 1 | One-cycle strobe: a distance is present |
| dist_value | output | 22 | Squared distance for one vector |
| dist_class | output | 3 | Class of that vector |
| done | output | 1 | All vectors of all classes compared for the pixel |

## Verification
The distance path is driven with a mid-range pixel against a weight pattern that is distinct at every address, so any wrong band packing, address layout or class order gives a wrong value. Two extreme pixels (all zero and all full-scale) are run against alternating all-zero and all-full-scale classes, which tells correct signed differencing and full 22-bit width apart from truncated or unsigned arithmetic. Vector counts of 0, 2, 3, 8 and 15 separate correct clamping from raw use of the configuration. Back-to-back pixels with the largest count show whether the running sum is cleared between vectors and between pixels.

// File: rtl/sqd_pkg.sv
package sqd_pkg;
    typedef enum logic [2:0] {
        ST_LINK  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_RUN   = 3'd2,
        ST_DRAIN = 3'd3,
        ST_FIN   = 3'd4
    } sqd_state_e;
endpackage

// File: rtl/sqd_wram.sv
module sqd_wram #(
    parameter int DW    = 10,
    parameter int DEPTH = 160,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Write port: the host loads training vectors at any time.
    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH))
            mem[waddr] <= wdata;
    end

    // Read port: registered, so the data arrives one cycle after the address.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/sqd_band_mac.sv
module sqd_band_mac #(
    parameter int PIX_W = 10,
    parameter int BANDS = 4,
    parameter int CLS_W = 3,
    localparam int SQ_W  = 2 * PIX_W,
    localparam int ACC_W = SQ_W + $clog2(BANDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_first,
    input  logic             in_last,
    input  logic [CLS_W-1:0] in_cls,
    input  logic [PIX_W-1:0] pix_s,
    input  logic [PIX_W-1:0] wgt_s,
    output logic             out_vld,
    output logic [ACC_W-1:0] out_dist,
    output logic [CLS_W-1:0] out_cls
);
    logic signed [PIX_W:0]     diff;
    logic signed [2*PIX_W+1:0] prod;
    logic [SQ_W-1:0]           sq;
    logic [ACC_W-1:0]          acc;

    always_comb begin
        diff = $signed({1'b0, pix_s}) - $signed({1'b0, wgt_s});
        prod = diff * diff;
        sq   = prod[SQ_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc      <= '0;
            out_vld  <= 1'b0;
            out_dist <= '0;
            out_cls  <= '0;
        end else begin
            out_vld <= 1'b0;
            if (in_vld) begin
                if (in_first)
                    acc <= ACC_W'(sq);
                else
                    acc <= acc + ACC_W'(sq);
                if (in_last) begin
                    out_vld  <= 1'b1;
                    out_dist <= (in_first ? '0 : acc) + ACC_W'(sq);
                    out_cls  <= in_cls;
                end
            end
        end
    end
endmodule

// File: rtl/sqd_ctrl.sv
module sqd_ctrl
    import sqd_pkg::*;
#(
    parameter int CLASSES = 5,
    parameter int MAX_WPC = 8,
    parameter int BANDS   = 4,
    localparam int CLS_W  = (CLASSES > 1) ? $clog2(CLASSES) : 1,
    localparam int WGT_W  = (MAX_WPC > 1) ? $clog2(MAX_WPC) : 1,
    localparam int BAND_W = (BANDS > 1) ? $clog2(BANDS) : 1,
    localparam int WPC_W  = $clog2(MAX_WPC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_ack,
    input  logic              pix_valid,
    input  logic [WPC_W-1:0]  wpc_cfg,
    output logic              link_rdy,
    output logic              pix_req,
    output logic              done,
    output logic              accept,
    output logic              iss_vld,
    output logic              iss_first,
    output logic              iss_last,
    output logic [CLS_W-1:0]  iss_cls,
    output logic [WGT_W-1:0]  iss_wgt,
    output logic [BAND_W-1:0] iss_band
);
    sqd_state_e state, nxt;

    logic [CLS_W-1:0]  cls_q;
    logic [WGT_W-1:0]  wgt_q;
    logic [BAND_W-1:0] band_q;
    logic [WPC_W-1:0]  wpc_eff;
    logic              band_end, wgt_end, cls_end, last_issue;

    always_comb begin
        band_end   = (int'(band_q) == BANDS - 1);
        wgt_end    = (WPC_W'(wgt_q) == wpc_eff - WPC_W'(1));
        cls_end    = (int'(cls_q) == CLASSES - 1);
        last_issue = band_end && wgt_end && cls_end;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LINK;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_LINK:  if (link_ack)   nxt = ST_IDLE;
            ST_IDLE:  if (pix_valid)  nxt = ST_RUN;
            ST_RUN:   if (last_issue) nxt = ST_DRAIN;
            ST_DRAIN:                 nxt = ST_FIN;
            ST_FIN:                   nxt = ST_IDLE;
            default:                  nxt = ST_LINK;
        endcase
    end

    // Outputs
    always_comb begin
        link_rdy  = (state == ST_LINK);
        pix_req   = (state == ST_IDLE);
        done      = (state == ST_FIN);
        accept    = (state == ST_IDLE) && pix_valid;
        iss_vld   = (state == ST_RUN);
        iss_first = (band_q == '0);
        iss_last  = band_end;
        iss_cls   = cls_q;
        iss_wgt   = wgt_q;
        iss_band  = band_q;
    end

    // Class / vector / band walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q   <= '0;
            wgt_q   <= '0;
            band_q  <= '0;
            wpc_eff <= WPC_W'(1);
        end else if (accept) begin
            cls_q  <= '0;
            wgt_q  <= '0;
            band_q <= '0;
            if (wpc_cfg == '0)
                wpc_eff <= WPC_W'(1);
            else if (int'(wpc_cfg) > MAX_WPC)
                wpc_eff <= WPC_W'(MAX_WPC);
            else
                wpc_eff <= wpc_cfg;
        end else if (state == ST_RUN) begin
            if (!band_end) begin
                band_q <= band_q + BAND_W'(1);
            end else begin
                band_q <= '0;
                if (!wgt_end) begin
                    wgt_q <= wgt_q + WGT_W'(1);
                end else begin
                    wgt_q <= '0;
                    if (!cls_end) cls_q <= cls_q + CLS_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sqd_accum.sv
module sqd_accum #(
    parameter int PIX_W   = 10,
    parameter int BANDS   = 4,
    parameter int CLASSES = 5,
    parameter int MAX_WPC = 8,
    localparam int CLS_W  = (CLASSES > 1) ? $clog2(CLASSES) : 1,
    localparam int WGT_W  = (MAX_WPC > 1) ? $clog2(MAX_WPC) : 1,
    localparam int BAND_W = (BANDS > 1) ? $clog2(BANDS) : 1,
    localparam int WPC_W  = $clog2(MAX_WPC + 1),
    localparam int DEPTH  = CLASSES * MAX_WPC * BANDS,
    localparam int AW     = $clog2(DEPTH),
    localparam int DIST_W = 2 * PIX_W + $clog2(BANDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic                   link_rdy,
    input  logic                   link_ack,
    input  logic [WPC_W-1:0]       wpc_cfg,
    output logic                   pix_req,
    input  logic                   pix_valid,
    input  logic [BANDS*PIX_W-1:0] pix_data,
    input  logic                   wmem_we,
    input  logic [AW-1:0]          wmem_addr,
    input  logic [PIX_W-1:0]       wmem_wdata,
    output logic                   dist_valid,
    output logic [DIST_W-1:0]      dist_value,
    output logic [CLS_W-1:0]       dist_class,
    output logic                   done
);
    logic              accept, iss_vld, iss_first, iss_last;
    logic [CLS_W-1:0]  iss_cls;
    logic [WGT_W-1:0]  iss_wgt;
    logic [BAND_W-1:0] iss_band;
    logic [AW-1:0]     raddr;
    logic [PIX_W-1:0]  wgt_rd;

    logic                   vld_d, first_d, last_d;
    logic [CLS_W-1:0]       cls_d;
    logic [BAND_W-1:0]      band_d;
    logic [BANDS*PIX_W-1:0] pix_q;
    logic [PIX_W-1:0]       pix_band [BANDS];
    logic [PIX_W-1:0]       pix_sel;

    sqd_ctrl #(
        .CLASSES (CLASSES),
        .MAX_WPC (MAX_WPC),
        .BANDS   (BANDS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_ack  (link_ack),
        .pix_valid (pix_valid),
        .wpc_cfg   (wpc_cfg),
        .link_rdy  (link_rdy),
        .pix_req   (pix_req),
        .done      (done),
        .accept    (accept),
        .iss_vld   (iss_vld),
        .iss_first (iss_first),
        .iss_last  (iss_last),
        .iss_cls   (iss_cls),
        .iss_wgt   (iss_wgt),
        .iss_band  (iss_band)
    );

    always_comb begin
        raddr = AW'(((int'(iss_cls) * MAX_WPC) + int'(iss_wgt)) * BANDS + int'(iss_band));
    end

    sqd_wram #(
        .DW    (PIX_W),
        .DEPTH (DEPTH)
    ) u_wram (
        .clk   (clk),
        .we    (wmem_we),
        .waddr (wmem_addr),
        .wdata (wmem_wdata),
        .raddr (raddr),
        .rdata (wgt_rd)
    );

    // Tags travel alongside the registered weight read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_d   <= 1'b0;
            first_d <= 1'b0;
            last_d  <= 1'b0;
            cls_d   <= '0;
            band_d  <= '0;
        end else begin
            vld_d   <= iss_vld;
            first_d <= iss_first;
            last_d  <= iss_last;
            cls_d   <= iss_cls;
            band_d  <= iss_band;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pix_q <= '0;
        else if (accept) pix_q <= pix_data;
    end

    for (genvar b = 0; b < BANDS; b++) begin : g_band
        assign pix_band[b] = pix_q[b*PIX_W +: PIX_W];
    end

    always_comb begin
        pix_sel = pix_band[band_d];
    end

    sqd_band_mac #(
        .PIX_W (PIX_W),
        .BANDS (BANDS),
        .CLS_W (CLS_W)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (vld_d),
        .in_first (first_d),
        .in_last  (last_d),
        .in_cls   (cls_d),
        .pix_s    (pix_sel),
        .wgt_s    (wgt_rd),
        .out_vld  (dist_valid),
        .out_dist (dist_value),
        .out_cls  (dist_class)
    );
endmodule

// File: rtl/sqd_accum_chk.sv
module sqd_accum_chk #(
    parameter int CLASSES = 5,
    parameter int CLS_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_rdy,
    input logic             link_ack,
    input logic             pix_req,
    input logic             pix_valid,
    input logic             dist_valid,
    input logic [CLS_W-1:0] dist_class,
    input logic             done
);
    // R1
    link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_rdy && !link_ack) |=> link_rdy);

    // R1
    link_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_rdy |-> (!pix_req && !dist_valid && !done));

    // R2
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && pix_valid) |=> !pix_req);

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dist_valid |=> !dist_valid);

    // R4
    class_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dist_valid |-> (int'(dist_class) < CLASSES));

    // R8
    done_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> dist_valid);

    // R8
    done_then_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (pix_req && !done));
endmodule

bind sqd_accum sqd_accum_chk #(
    .CLASSES (CLASSES),
    .CLS_W   (CLS_W)
) u_sqd_accum_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_rdy   (link_rdy),
    .link_ack   (link_ack),
    .pix_req    (pix_req),
    .pix_valid  (pix_valid),
    .dist_valid (dist_valid),
    .dist_class (dist_class),
    .done       (done)
);

// File: tb/tb_sqd_accum.sv
module tb_sqd_accum;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W   = 10;
    localparam int BANDS   = 4;
    localparam int CLASSES = 5;
    localparam int MAX_WPC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_rdy, link_ack = 1'b0;
    logic [3:0]  wpc_cfg = '0;
    logic        pix_req, pix_valid = 1'b0;
    logic [39:0] pix_data = '0;
    logic        wmem_we = 1'b0;
    logic [7:0]  wmem_addr = '0;
    logic [9:0]  wmem_wdata = '0;
    logic        dist_valid;
    logic [21:0] dist_value;
    logic [2:0]  dist_class;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    int wmodel [CLASSES][MAX_WPC][BANDS];
    int cur_pix [BANDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    sqd_accum dut (
        .clk(clk), .rst_n(rst_n), .link_rdy(link_rdy), .link_ack(link_ack),
        .wpc_cfg(wpc_cfg), .pix_req(pix_req), .pix_valid(pix_valid),
        .pix_data(pix_data), .wmem_we(wmem_we), .wmem_addr(wmem_addr),
        .wmem_wdata(wmem_wdata), .dist_valid(dist_valid),
        .dist_value(dist_value), .dist_class(dist_class), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Weight store layout (R4): address (c*8 + w)*4 + b
    task automatic load_weights(input int mode);
        for (int c = 0; c < CLASSES; c++)
            for (int w = 0; w < MAX_WPC; w++)
                for (int b = 0; b < BANDS; b++) begin
                    int v;
                    if (mode == 0) v = (c * 211 + w * 97 + b * 41 + 7) % 1024;
                    else           v = (c % 2 == 0) ? 1023 : 0;
                    wmodel[c][w][b] = v;
                    @(negedge clk);
                    wmem_we    = 1'b1;
                    wmem_addr  = 8'((c * MAX_WPC + w) * BANDS + b);
                    wmem_wdata = 10'(v);
                end
        @(negedge clk);
        wmem_we = 1'b0;
    endtask

    function automatic int ref_dist(input int c, input int w);
        int s = 0;
        for (int b = 0; b < BANDS; b++)
            s += (cur_pix[b] - wmodel[c][w][b]) * (cur_pix[b] - wmodel[c][w][b]);
        return s;
    endfunction

    // Sends cur_pix and checks every output of that pixel (R2..R8)
    task automatic run_pixel(input int wpc, input string tag);
        int n, nout, last_cyc, cyc;
        bit got_done;
        n = (wpc == 0) ? 1 : ((wpc > MAX_WPC) ? MAX_WPC : wpc);   // R7
        @(negedge clk);
        chk(pix_req === 1'b1, {"R2 request before ", tag}, pix_req, 1);
        for (int b = 0; b < BANDS; b++) pix_data[b*PIX_W +: PIX_W] = 10'(cur_pix[b]);
        wpc_cfg   = 4'(wpc);
        pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        chk(pix_req === 1'b0, {"R2 request drops ", tag}, pix_req, 0);
        nout = 0; last_cyc = -100; cyc = 0; got_done = 0;
        while (!got_done && cyc < 2000) begin
            if (dist_valid === 1'b1) begin
                int c = nout / n;
                int w = nout % n;
                int e = ref_dist(c, w);
                chk(int'(dist_value) == e && int'(dist_class) == c,
                    {"R3/R4/R6 distance ", tag}, dist_value, e);
                if (nout > 0)
                    chk(cyc - last_cyc == BANDS, {"R5 strobe spacing ", tag}, cyc - last_cyc, BANDS);
                last_cyc = cyc;
                nout++;
            end
            if (done === 1'b1) begin
                got_done = 1;
                chk(dist_valid === 1'b1, {"R8 done with final distance ", tag}, dist_valid, 1);
            end
            @(negedge clk);
            cyc++;
        end
        chk(nout == CLASSES * n, {"R5/R7 strobe count ", tag}, nout, CLASSES * n);
        chk(got_done, {"R8 done seen ", tag}, got_done, 1);
        chk(pix_req === 1'b1 && done === 1'b0, {"R8 request after done ", tag}, pix_req, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(link_rdy === 1'b1, "R1 link_rdy after reset", link_rdy, 1);
        chk(pix_req === 1'b0 && dist_valid === 1'b0 && done === 1'b0,
            "R1 outputs quiet after reset", {pix_req, dist_valid, done}, 0);
    endtask

    task automatic t_link();
        pix_data  = 40'h12345_6789A;
        pix_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(link_rdy === 1'b1 && pix_req === 1'b0 && dist_valid === 1'b0,
                "R1 pixel ignored before ack", {link_rdy, pix_req, dist_valid}, 3'b100);
        end
        pix_valid = 1'b0;
        link_ack  = 1'b1;
        @(negedge clk);
        link_ack = 1'b0;
        chk(link_rdy === 1'b0 && pix_req === 1'b1, "R2 request after ack",
            {link_rdy, pix_req}, 2'b01);
    endtask

    task automatic t_basic();
        load_weights(0);
        cur_pix = '{100, 500, 900, 3};
        run_pixel(2, "basic");
    endtask

    task automatic t_extreme();
        load_weights(1);
        cur_pix = '{0, 0, 0, 0};
        run_pixel(3, "zero pixel");           // R3: even classes give 4186116
        cur_pix = '{1023, 1023, 1023, 1023};
        run_pixel(3, "full pixel");           // R3: odd classes give 4186116
    endtask

    task automatic t_clamp();
        load_weights(0);
        cur_pix = '{17, 1000, 256, 640};
        run_pixel(0, "wpc zero");             // R7
        run_pixel(15, "wpc above max");       // R7
    endtask

    task automatic t_b2b();
        cur_pix = '{1023, 0, 511, 512};
        run_pixel(8, "back to back A");       // R6
        cur_pix = '{1, 2, 3, 4};
        run_pixel(8, "back to back B");       // R6
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_link();
        t_basic();
        t_extreme();
        t_clamp();
        t_b2b();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule